// File: doc/BRIEF.md
# Multi-Resolution Bus Signal Abstractor

This block watches an AHB-style bus and turns it into a stream of trace records at a granularity chosen at run time. The bus signals are sorted into four groups: instruction-fetch address, data address and value, access attributes, and handshake signals. Alternatively the bus is reduced to a small bus-state code. Records are taken either on every cycle or only when something has changed. A fifth level keeps only the cycles in which a master actually completes or fails a transfer.

The level can be changed while tracing runs. Each switch puts a marker record into the stream and restarts change detection, so the first sample under the new level is always recorded. Records leave through a registered valid/ready port. While `rec_valid` is high and `rec_ready` is low, the record is held unchanged. Any record that arises during that stall is discarded. Change detection compares against the last record actually emitted, so in the two change-only levels a difference that was dropped reappears once the port frees up. A requested level switch waits until the port can accept its marker, so markers are never lost.

Top module: `bus_abstractor`

## Requirements
- R1: After reset `rec_valid` is 0 and the active level is 1.
- R2: In level 1, every tracing cycle with a free output slot yields a sample record one clock later, tagged with mode 1. Its fields are as follows. `rec_pc` is `haddr` when `hprot[0]`=0, otherwise 0. `rec_daddr` is `haddr` when `hprot[0]`=1, otherwise 0. `rec_dval` is `hwdata` when `hwrite`=1, otherwise `hrdata`. `rec_acc` is {hwrite, hsize, hburst, hprot}, from bit 10 down. `rec_proto` is {htrans, hready, hresp}, from bit 4 down.
- R3: In level 2, a sample record is emitted only when the grouped fields differ from the last emitted record, or when no record has been emitted since history was cleared.
- R4: The bus state code is computed in this priority order. ERROR (4) when hresp=2'b01. Otherwise IDLE (0) when htrans=2'b00. Otherwise BUSY (1) when htrans=2'b01. Otherwise WAIT (2) when hready=0. Otherwise NORMAL (3). Level 3 emits this code on every cycle.
- R5: Level 4 emits the state code only when it differs from the last emitted one, or when history is empty.
- R6: Level 5 emits only on a cycle whose state is NORMAL or ERROR and differs from the previous tracing cycle's state, or when there was no previous tracing cycle. It stays silent in IDLE, WAIT and BUSY.
- R7: A request for a legal level that differs from the active one, made while tracing, emits one marker record. The marker has `rec_marker`=1, carries the new level as its tag and has all other fields 0. The switch clears all history, and the bus sample of that cycle is not recorded.
- R8: `mode_sel` values 0, 6 and 7 are ignored, and the active level is kept.
- R9: While `trace_on` is 0 nothing new is emitted, history is cleared, and level requests take effect silently without a marker.
- R10: While `rec_valid`=1 and `rec_ready`=0 the record is held unchanged. Records that arise during the stall are discarded, and a requested switch waits until the slot is free.
- R11: Sample records in levels 3 to 5 carry 0 in `rec_pc`, `rec_daddr`, `rec_dval`, `rec_acc` and `rec_proto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trace_on | input | 1 | Tracing enabled |
| mode_sel | input | 3 | Requested level, 1 to 5 |
| haddr | input | AW | Bus address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write direction |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type |
| hprot | input | 4 | Protection; bit 0 selects data versus fetch |
| hwdata | input | DW | Write data |
| hrdata | input | DW | Read data |
| hready | input | 1 | Transfer ready |
| hresp | input | 2 | Transfer response |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Consumer accepts record |
| rec_marker | output | 1 | Record is a level-switch marker |
| rec_mode | output | 3 | Level tag |
| rec_state | output | 3 | Bus state code |
| rec_pc | output | AW | Fetch address group |
| rec_daddr | output | AW | Data address group |
| rec_dval | output | DW | Data value group |
| rec_acc | output | 11 | Access attribute group |
| rec_proto | output | 5 | Handshake group |

## Verification
The bench builds the block with AW=16 and DW=8. At these widths the randomly held or repeated bus values often match the last emitted record, so the change-only levels face both suppressed and emitted cycles. Random back-pressure, combined with mid-run level switches, brings deferred markers and discarded records within reach. Directed cycles cover the decode priority corners, for example an ERROR response during an IDLE transfer.

// File: rtl/bus_abs_pkg.sv
package bus_abs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BUSY   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_NORMAL = 3'd3,
    ST_ERROR  = 3'd4
  } bstate_e;

  localparam int ACC_W   = 11;
  localparam int PROTO_W = 5;

  localparam logic [1:0] TR_IDLE  = 2'b00;
  localparam logic [1:0] TR_BUSY  = 2'b01;
  localparam logic [1:0] RSP_ERR  = 2'b01;

  localparam logic [2:0] LVL_FULL_CYC = 3'd1;
  localparam logic [2:0] LVL_FULL_CHG = 3'd2;
  localparam logic [2:0] LVL_ST_CYC   = 3'd3;
  localparam logic [2:0] LVL_ST_CHG   = 3'd4;
  localparam logic [2:0] LVL_MASTER   = 3'd5;

  function automatic logic lvl_legal(input logic [2:0] m);
    return (m >= LVL_FULL_CYC) && (m <= LVL_MASTER);
  endfunction
endpackage

// File: rtl/bus_state_decode.sv
module bus_state_decode
  import bus_abs_pkg::*;
(
  input  logic [1:0] htrans,
  input  logic       hready,
  input  logic [1:0] hresp,
  output bstate_e    state
);
  always_comb begin
    if (hresp == RSP_ERR)       state = ST_ERROR;
    else if (htrans == TR_IDLE) state = ST_IDLE;
    else if (htrans == TR_BUSY) state = ST_BUSY;
    else if (!hready)           state = ST_WAIT;
    else                        state = ST_NORMAL;
  end
endmodule

// File: rtl/sig_grouper.sv
module sig_grouper
  import bus_abs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]      haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic [2:0]         hburst,
  input  logic [3:0]         hprot,
  input  logic [DW-1:0]      hwdata,
  input  logic [DW-1:0]      hrdata,
  input  logic               hready,
  input  logic [1:0]         hresp,
  output logic [AW-1:0]      g_pc,
  output logic [AW-1:0]      g_daddr,
  output logic [DW-1:0]      g_dval,
  output logic [ACC_W-1:0]   g_acc,
  output logic [PROTO_W-1:0] g_proto
);
  logic is_data;
  assign is_data = hprot[0];

  assign g_pc    = is_data ? '0 : haddr;
  assign g_daddr = is_data ? haddr : '0;
  assign g_dval  = hwrite ? hwdata : hrdata;
  assign g_acc   = {hwrite, hsize, hburst, hprot};
  assign g_proto = {htrans, hready, hresp};
endmodule

// File: rtl/level_filter.sv
module level_filter
  import bus_abs_pkg::*;
#(
  parameter int GW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_on,
  input  logic [2:0]    mode_sel,
  input  logic          slot_free,
  input  logic [GW-1:0] grp,
  input  bstate_e       state,
  output logic          emit,
  output logic          is_marker,
  output logic [2:0]    tag,
  output logic [2:0]    cur_mode
);
  logic [2:0]    mode_q;
  logic [GW-1:0] hist_grp;
  bstate_e       hist_st;
  logic          hist_v;
  bstate_e       prev_st;
  logic          prev_v;

  logic sw_req, sw_take, want, is_master;

  assign sw_req    = lvl_legal(mode_sel) && (mode_sel != mode_q);
  assign sw_take   = trace_on && sw_req && slot_free;
  assign is_master = (state == ST_NORMAL) || (state == ST_ERROR);

  always_comb begin
    unique case (mode_q)
      LVL_FULL_CHG: want = !hist_v || (grp != hist_grp);
      LVL_ST_CHG:   want = !hist_v || (state != hist_st);
      LVL_MASTER:   want = is_master && (!prev_v || (state != prev_st));
      default:      want = 1'b1;
    endcase
  end

  assign emit      = trace_on && slot_free && (sw_take || want);
  assign is_marker = sw_take;
  assign tag       = sw_take ? mode_sel : mode_q;
  assign cur_mode  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= LVL_FULL_CYC;
      hist_grp <= '0;
      hist_st  <= ST_IDLE;
      hist_v   <= 1'b0;
      prev_st  <= ST_IDLE;
      prev_v   <= 1'b0;
    end else if (!trace_on) begin
      hist_v <= 1'b0;
      prev_v <= 1'b0;
      if (sw_req) mode_q <= mode_sel;
    end else if (sw_take) begin
      mode_q <= mode_sel;
      hist_v <= 1'b0;
      prev_v <= 1'b0;
    end else begin
      prev_st <= state;
      prev_v  <= 1'b1;
      if (emit) begin
        hist_grp <= grp;
        hist_st  <= state;
        hist_v   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_abstractor.sv
module bus_abstractor
  import bus_abs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_on,
  input  logic [2:0]         mode_sel,
  input  logic [AW-1:0]      haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic [2:0]         hburst,
  input  logic [3:0]         hprot,
  input  logic [DW-1:0]      hwdata,
  input  logic [DW-1:0]      hrdata,
  input  logic               hready,
  input  logic [1:0]         hresp,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic               rec_marker,
  output logic [2:0]         rec_mode,
  output logic [2:0]         rec_state,
  output logic [AW-1:0]      rec_pc,
  output logic [AW-1:0]      rec_daddr,
  output logic [DW-1:0]      rec_dval,
  output logic [ACC_W-1:0]   rec_acc,
  output logic [PROTO_W-1:0] rec_proto
);
  localparam int GW = 2 * AW + DW + ACC_W + PROTO_W;

  bstate_e            st;
  logic [AW-1:0]      g_pc, g_daddr;
  logic [DW-1:0]      g_dval;
  logic [ACC_W-1:0]   g_acc;
  logic [PROTO_W-1:0] g_proto;
  logic               slot_free, emit, is_marker, full_lvl;
  logic [2:0]         tag, cur_mode;

  bus_state_decode u_dec (
    .htrans (htrans),
    .hready (hready),
    .hresp  (hresp),
    .state  (st)
  );

  sig_grouper #(.AW(AW), .DW(DW)) u_grp (
    .haddr   (haddr),
    .htrans  (htrans),
    .hwrite  (hwrite),
    .hsize   (hsize),
    .hburst  (hburst),
    .hprot   (hprot),
    .hwdata  (hwdata),
    .hrdata  (hrdata),
    .hready  (hready),
    .hresp   (hresp),
    .g_pc    (g_pc),
    .g_daddr (g_daddr),
    .g_dval  (g_dval),
    .g_acc   (g_acc),
    .g_proto (g_proto)
  );

  assign slot_free = !rec_valid || rec_ready;

  level_filter #(.GW(GW)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_on  (trace_on),
    .mode_sel  (mode_sel),
    .slot_free (slot_free),
    .grp       ({g_pc, g_daddr, g_dval, g_acc, g_proto}),
    .state     (st),
    .emit      (emit),
    .is_marker (is_marker),
    .tag       (tag),
    .cur_mode  (cur_mode)
  );

  assign full_lvl = !is_marker && (tag <= LVL_FULL_CHG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid  <= 1'b0;
      rec_marker <= 1'b0;
      rec_mode   <= LVL_FULL_CYC;
      rec_state  <= ST_IDLE;
      rec_pc     <= '0;
      rec_daddr  <= '0;
      rec_dval   <= '0;
      rec_acc    <= '0;
      rec_proto  <= '0;
    end else if (slot_free) begin
      rec_valid <= emit;
      if (emit) begin
        rec_marker <= is_marker;
        rec_mode   <= tag;
        rec_state  <= is_marker ? ST_IDLE : st;
        rec_pc     <= full_lvl ? g_pc    : '0;
        rec_daddr  <= full_lvl ? g_daddr : '0;
        rec_dval   <= full_lvl ? g_dval  : '0;
        rec_acc    <= full_lvl ? g_acc   : '0;
        rec_proto  <= full_lvl ? g_proto : '0;
      end
    end
  end
endmodule

// File: rtl/bus_abs_chk.sv
module bus_abs_chk
  import bus_abs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trace_on,
  input logic               rec_valid,
  input logic               rec_ready,
  input logic               rec_marker,
  input logic [2:0]         rec_mode,
  input logic [2:0]         rec_state,
  input logic [AW-1:0]      rec_pc,
  input logic [AW-1:0]      rec_daddr,
  input logic [DW-1:0]      rec_dval,
  input logic [ACC_W-1:0]   rec_acc,
  input logic [PROTO_W-1:0] rec_proto,
  input logic [2:0]         cur_mode
);
  a_r10_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid &&
      $stable({rec_marker, rec_mode, rec_state, rec_pc, rec_daddr, rec_dval, rec_acc, rec_proto})));

  a_r9_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_on && (!rec_valid || rec_ready)) |=> !rec_valid);

  a_r2_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_mode >= 3'd1 && rec_mode <= 3'd5));

  a_r11_state_level_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_marker && rec_mode >= 3'd3) |->
      (rec_pc == '0 && rec_daddr == '0 && rec_dval == '0 && rec_acc == '0 && rec_proto == '0));

  a_r6_master_states: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_marker && rec_mode == 3'd5) |->
      (rec_state == 3'd3 || rec_state == 3'd4));

  a_r8_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode >= 3'd1 && cur_mode <= 3'd5));
endmodule

bind bus_abstractor bus_abs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trace_on   (trace_on),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_marker (rec_marker),
  .rec_mode   (rec_mode),
  .rec_state  (rec_state),
  .rec_pc     (rec_pc),
  .rec_daddr  (rec_daddr),
  .rec_dval   (rec_dval),
  .rec_acc    (rec_acc),
  .rec_proto  (rec_proto),
  .cur_mode   (cur_mode)
);

// File: tb/tb_bus_abstractor.sv
module tb_bus_abstractor;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, trace_on = 0;
  logic [2:0] mode_sel = 3'd1;
  logic [AW-1:0] haddr = '0;
  logic [1:0] htrans = 0, hresp = 0;
  logic hwrite = 0, hready = 1, rec_ready = 1;
  logic [2:0] hsize = 0, hburst = 0;
  logic [3:0] hprot = 0;
  logic [DW-1:0] hwdata = 0, hrdata = 0;
  logic rec_valid, rec_marker;
  logic [2:0] rec_mode, rec_state;
  logic [AW-1:0] rec_pc, rec_daddr;
  logic [DW-1:0] rec_dval;
  logic [10:0] rec_acc;
  logic [4:0] rec_proto;

  always #4 clk = ~clk;

  bus_abstractor #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .mode_sel(mode_sel),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hprot(hprot), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_marker(rec_marker), .rec_mode(rec_mode), .rec_state(rec_state),
    .rec_pc(rec_pc), .rec_daddr(rec_daddr), .rec_dval(rec_dval),
    .rec_acc(rec_acc), .rec_proto(rec_proto)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_mode = 1;
  bit h_v = 0, p_v = 0;
  logic [63:0] h_grp = 0;
  int h_st = 0, p_st = 0;
  bit e_valid = 0, e_marker = 0;
  int e_mode = 1, e_state = 0;
  logic [63:0] e_pc = 0, e_da = 0, e_dv = 0, e_acc = 0, e_pr = 0;

  function automatic int ref_state();
    if (hresp == 2'b01) return 4;
    if (htrans == 2'b00) return 0;
    if (htrans == 2'b01) return 1;
    if (!hready) return 2;
    return 3;
  endfunction

  task automatic model_step();
    bit free, sw, emit, mk, want;
    int st, tag;
    logic [63:0] pc, da, dv, acc, pr, grp;
    free = !e_valid || rec_ready;
    st = ref_state();
    pc = hprot[0] ? 64'd0 : 64'(haddr);
    da = hprot[0] ? 64'(haddr) : 64'd0;
    dv = hwrite ? 64'(hwdata) : 64'(hrdata);
    acc = 64'({hwrite, hsize, hburst, hprot});
    pr = 64'({htrans, hready, hresp});
    grp = pc ^ (da << 16) ^ (dv << 32) ^ (acc << 40) ^ (pr << 51);
    sw = (mode_sel >= 1 && mode_sel <= 5) && (int'(mode_sel) != m_mode);
    emit = 0; mk = 0; tag = m_mode;
    if (!trace_on) begin
      h_v = 0; p_v = 0;
      if (sw) m_mode = mode_sel;
    end else if (sw && free) begin
      emit = 1; mk = 1; tag = mode_sel; m_mode = mode_sel; h_v = 0; p_v = 0;
    end else begin
      case (m_mode)
        2: want = !h_v || grp != h_grp;
        4: want = !h_v || st != h_st;
        5: want = (st == 3 || st == 4) && (!p_v || st != p_st);
        default: want = 1;
      endcase
      if (want && free) begin
        emit = 1; h_grp = grp; h_st = st; h_v = 1;
      end
      p_st = st; p_v = 1;
    end
    if (free) begin
      e_valid = emit;
      if (emit) begin
        e_marker = mk; e_mode = tag; e_state = mk ? 0 : st;
        if (!mk && tag <= 2) begin
          e_pc = pc; e_da = da; e_dv = dv; e_acc = acc; e_pr = pr;
        end else begin
          e_pc = 0; e_da = 0; e_dv = 0; e_acc = 0; e_pr = 0;
        end
      end
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("valid", 64'(rec_valid), 64'(e_valid));
    if (e_valid && rec_valid) begin
      chk("marker", 64'(rec_marker), 64'(e_marker));
      chk("mode", 64'(rec_mode), 64'(e_mode));
      chk("state", 64'(rec_state), 64'(e_state));
      chk("pc", 64'(rec_pc), e_pc);
      chk("daddr", 64'(rec_daddr), e_da);
      chk("dval", 64'(rec_dval), e_dv);
      chk("acc", 64'(rec_acc), e_acc);
      chk("proto", 64'(rec_proto), e_pr);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #2 compare();
  endtask

  task automatic rnd_bus(int hold);
    if (int'($urandom % 100) < hold) return;
    haddr = AW'($urandom % 4);
    htrans = 2'($urandom);
    hwrite = 1'($urandom);
    hsize = 3'($urandom % 2);
    hburst = 3'($urandom % 2);
    hprot = 4'($urandom % 2);
    hwdata = DW'($urandom % 3);
    hrdata = DW'($urandom % 3);
    hready = ($urandom % 4) != 0;
    hresp = ($urandom % 6 == 0) ? 2'b01 : (($urandom % 10 == 0) ? 2'b10 : 2'b00);
  endtask

  task automatic run(int n, int hold);
    for (int i = 0; i < n; i++) begin
      rnd_bus(hold);
      tick();
    end
  endtask

  task automatic set_bus(logic [1:0] tr, logic rdy, logic [1:0] rsp);
    htrans = tr; hready = rdy; hresp = rsp;
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) begin
      @(posedge clk); #2 chk("valid in reset", 64'(rec_valid), 64'd0);
    end
    @(negedge clk); rst_n = 1;
    tick();
    chk("idle after reset", 64'(rec_valid), 64'd0);

    // R2: level 1, every cycle, field packing
    cur_req = "R2";
    trace_on = 1; mode_sel = 3'd1;
    run(30, 0);
    haddr = 16'h1234; hprot = 4'b0001; hwrite = 1; hwdata = 8'h5a; hrdata = 8'h11;
    hsize = 3'd2; hburst = 3'd3; set_bus(2'b10, 1, 2'b00);
    tick(); tick();
    chk("R2 daddr direct", 64'(rec_daddr), 64'h1234);
    chk("R2 pc direct", 64'(rec_pc), 64'd0);
    chk("R2 acc direct", 64'(rec_acc), 64'b1_010_011_0001);

    // R7/R3: switch to level 2
    cur_req = "R7";
    mode_sel = 3'd2; tick();
    chk("R7 marker direct", 64'(rec_marker), 64'd1);
    cur_req = "R3";
    run(50, 70);

    // R4: level 3 plus priority corners
    cur_req = "R4";
    mode_sel = 3'd3; run(30, 0);
    set_bus(2'b00, 0, 2'b01); tick(); tick();
    chk("R4 error beats idle", 64'(rec_state), 64'd4);
    set_bus(2'b11, 0, 2'b00); tick(); tick();
    chk("R4 wait", 64'(rec_state), 64'd2);
    set_bus(2'b01, 0, 2'b00); tick(); tick();
    chk("R4 busy beats wait", 64'(rec_state), 64'd1);
    cur_req = "R11";
    run(10, 0);

    cur_req = "R5";
    mode_sel = 3'd4; run(50, 60);

    cur_req = "R6";
    mode_sel = 3'd5; run(60, 20);
    set_bus(2'b10, 1, 2'b00); tick();
    tick(); tick();
    chk("R6 repeated normal silent", 64'(rec_valid), 64'd0);

    cur_req = "R8";
    for (int k = 0; k < 3; k++) begin
      mode_sel = (k == 0) ? 3'd0 : ((k == 1) ? 3'd6 : 3'd7);
      run(6, 0);
    end

    cur_req = "R9";
    trace_on = 0; mode_sel = 3'd1; run(10, 0);
    trace_on = 1; run(5, 0);

    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      rec_ready = ($urandom % 3) != 0;
      if ($urandom % 25 == 0) mode_sel = 3'($urandom % 8);
      if ($urandom % 60 == 0) trace_on = !trace_on;
      rnd_bus(50);
      tick();
    end
    rec_ready = 1;
    run(5, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule